// File: doc/BRIEF.md
# Delay-Line Transition Position Encoder

This block turns a delay-chain snapshot into a fine-time bin number. A slow clock runs down a chain of delay taps. When a hit arrives, all taps are latched at once. The chain is longer than half a clock period, so a normal snapshot holds at least one level change, and often shows a zeros–ones–zeros shape. The encoder walks the taps from the chain input outward and stops at the first pair of neighbouring taps that differ.

It reports that position as a signed number. The number is positive when the level goes from low to high along the chain and negative when it goes from high to low. The magnitude is the position and the sign is the edge polarity. A downstream calibration stage converts this raw value into time.

Taps are numbered from 0, nearest the chain input. Bin k names the boundary between tap k-1 and tap k, so k runs from 1 to TAPS-1. A snapshot that is all zeros or all ones has no boundary. For such a snapshot the block raises an error flag and reports bin 0. The search is combinational from the snapshot port, and the result sits behind exactly one register stage.

Top module: `edge_bin_encoder`

## Requirements
- R1: While `rst_n` is low and after it is released, until the first strobe has been accepted, `bin_vld` is 0, `bin` is 0 and `no_edge` is 0.
- R2: `bin_vld` is high in the cycle after a cycle in which `snap_vld` was high, and low otherwise, so the latency is exactly one clock.
- R3: If the first differing pair of neighbouring taps, counted from tap 0, has tap k-1 = 0 and tap k = 1, then `bin` is +k as a two's-complement value.
- R4: If the first differing pair has tap k-1 = 1 and tap k = 0, then `bin` is -k as a two's-complement value.
- R5: Transitions after the first one have no effect on `bin`, whatever their number or polarity.
- R6: An all-zero or all-one snapshot sets `no_edge` to 1 and `bin` to 0.
- R7: When the snapshot has at least one transition, `no_edge` is 0 and `bin` is non-zero.
- R8: In a cycle that follows a cycle with `snap_vld` low, `bin` and `no_edge` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snap_vld | input | 1 | Strobe: `snap` holds a new snapshot |
| snap | input | TAPS | Latched tap levels, bit 0 nearest the chain input |
| bin_vld | output | 1 | Result strobe, one cycle after `snap_vld` |
| bin | output | BIN_W | Signed first-transition bin, two's complement |
| no_edge | output | 1 | Snapshot contained no transition |

## Verification
The bench builds the encoder with the default of 60 taps, so BIN_W is 7. With this setting every boundary from 1 to 59 can be reached in both polarities, and so can the largest magnitude that the 7-bit signed output has to carry. Multi-edge snapshots are used to show that later transitions are ignored: alternating bits, a pulse of ones, and isolated bits at either end. Both constant snapshots are used to exercise the error path.

// File: rtl/edge_bin_encoder.sv
module edge_bin_encoder #(
  parameter  int TAPS  = 60,
  localparam int POS_W = $clog2(TAPS),
  localparam int BIN_W = POS_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    snap_vld,
  input  logic [TAPS-1:0]         snap,
  output logic                    bin_vld,
  output logic signed [BIN_W-1:0] bin,
  output logic                    no_edge
);

  logic [TAPS-2:0]         diff;
  logic                    found;
  logic                    rise;
  logic [POS_W-1:0]        pos;
  logic signed [BIN_W-1:0] mag;
  logic signed [BIN_W-1:0] bin_nxt;

  assign diff = snap[TAPS-1:1] ^ snap[TAPS-2:0];

  always_comb begin
    found = 1'b0;
    rise  = 1'b0;
    pos   = '0;
    for (int i = 0; i < TAPS-1; i++) begin
      if (!found && diff[i]) begin
        found = 1'b1;
        rise  = snap[i+1];
        pos   = POS_W'(i + 1);
      end
    end
  end

  assign mag     = $signed({1'b0, pos});
  assign bin_nxt = !found ? '0 : (rise ? mag : -mag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bin_vld <= 1'b0;
      bin     <= '0;
      no_edge <= 1'b0;
    end else begin
      bin_vld <= snap_vld;
      if (snap_vld) begin
        bin     <= bin_nxt;
        no_edge <= !found;
      end
    end
  end

endmodule

// File: rtl/edge_bin_encoder_chk.sv
module edge_bin_encoder_chk #(
  parameter  int TAPS  = 60,
  localparam int BIN_W = $clog2(TAPS) + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    snap_vld,
  input logic [TAPS-1:0]         snap,
  input logic                    bin_vld,
  input logic signed [BIN_W-1:0] bin,
  input logic                    no_edge
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    bin_vld == $past(snap_vld)); // R2

  AST_SIGN_FOLLOWS_TAP0: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_vld && !no_edge) |-> ((bin > 0) == !$past(snap[0]))); // R3 R4

  AST_ZERO_ON_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_vld && no_edge) |-> (bin == 0)); // R6

  AST_NONZERO_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_vld && !no_edge) |-> (bin != 0)); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(snap_vld) |-> ($stable(bin) && $stable(no_edge))); // R8

endmodule

bind edge_bin_encoder edge_bin_encoder_chk #(.TAPS(TAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .snap_vld(snap_vld), .snap(snap),
  .bin_vld(bin_vld), .bin(bin), .no_edge(no_edge)
);

// File: tb/edge_bin_encoder_tb.sv
`timescale 1ns/1ps
module edge_bin_encoder_tb;
  localparam int TAPS  = 60;
  localparam int BIN_W = $clog2(TAPS) + 1;
  localparam int NV    = 8;

  localparam logic [TAPS-1:0] SNAP_T [NV] = '{
    60'h0000000000000F0,
    60'hFFFFFFFFFFFFF0F,
    60'h000000000000001,
    60'h800000000000000,
    60'h000000000000005,
    60'hAAAAAAAAAAAAAAA,
    60'h0FF000000000000,
    60'h555555555555555
  };
  localparam int BIN_T [NV] = '{4, -4, -1, 59, -1, 1, 48, -1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snap_vld = 1'b0;
  logic [TAPS-1:0] snap = '0;
  logic bin_vld;
  logic signed [BIN_W-1:0] bin;
  logic no_edge;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  edge_bin_encoder #(.TAPS(TAPS)) u_dut (
    .clk(clk), .rst_n(rst_n), .snap_vld(snap_vld), .snap(snap),
    .bin_vld(bin_vld), .bin(bin), .no_edge(no_edge)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [TAPS-1:0] s, input int exp_bin,
                       input int exp_err, input string req);
    @(negedge clk);
    snap = s;
    snap_vld = 1'b1;
    @(negedge clk);
    snap_vld = 1'b0;
    snap = ~s;
    check({req, " vld"}, int'(bin_vld), 1);
    check({req, " bin"}, int'(bin), exp_bin);
    check({req, " err"}, int'(no_edge), exp_err);
    @(negedge clk);
    check("R2 vld low", int'(bin_vld), 0);
    check("R8 hold bin", int'(bin), exp_bin);
    check("R8 hold err", int'(no_edge), exp_err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset vld", int'(bin_vld), 0);
    check("R1 reset bin", int'(bin), 0);
    check("R1 reset err", int'(no_edge), 0);
    rst_n = 1'b1;
    snap = {TAPS{1'b1}};
    repeat (2) @(negedge clk);
    check("R1 idle vld", int'(bin_vld), 0);
    check("R1 idle bin", int'(bin), 0);
    check("R1 idle err", int'(no_edge), 0);

    for (int v = 0; v < NV; v++)
      apply(SNAP_T[v], BIN_T[v], 0, "R5 table");

    for (int k = 1; k < TAPS; k++) begin
      apply({TAPS{1'b1}} << k, k, 0, "R3 sweep");
      apply(~({TAPS{1'b1}} << k), -k, 0, "R4 sweep");
    end

    apply('0, 0, 1, "R6 all zero");
    apply('1, 0, 1, "R6 all one");
    apply(60'h000000000000002, 1, 0, "R7 after flat");

    @(negedge clk);
    snap = 60'h000000000000010;
    snap_vld = 1'b1;
    @(negedge clk);
    snap = 60'h000000000000F00;
    @(negedge clk);
    snap_vld = 1'b0;
    check("R2 back-to-back vld", int'(bin_vld), 1);
    check("R3 back-to-back bin", int'(bin), 8);
    @(negedge clk);
    check("R2 back-to-back end", int'(bin_vld), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #100000;
    join_any
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule